// File: doc/BRIEF.md
# Serial Flash Status Register Write Guard

This block owns the status word of a serial flash device and decides, cycle by cycle, whether a status write or an array program or erase may start. The instruction decoder ahead of it hands over one-cycle strobes for write-enable, write-disable, status write, program and erase, together with the new status value. The block also takes in the active-low write-protect pin, a power-up reset and a pulse from the array sequencer that marks the end of an operation. It drives the 16-bit status word and two permission flags.

The status word holds two kinds of bits. Busy and the write-enable latch are volatile. The block-protect field, the top/bottom and sector/block selectors, the two protect-mode bits and the quad-enable bit keep their values across a power-up reset, and start at zero when the chip is first configured. A status write is held pending while busy is high and takes effect when the operation completes. Deciding which addresses the protect field covers is left to a neighbouring block.

Top module: `sreg_guard`

## Requirements
- R1: After the power-up reset `rst`, busy (bit 0) and the write-enable latch (bit 1) are 0. On first configuration the whole status word is 0, and both flags are 0.
- R2: A write-enable strobe sets bit 1 and a write-disable strobe clears it, in the cycle after the strobe.
- R3: A program or erase strobe while bit 1 is 0 is refused, and busy stays 0.
- R4: A program or erase strobe while bit 1 is 1 sets busy and clears bit 1 in the next cycle. Busy then stays 1 until an operation-done pulse, after which it is 0.
- R5: While busy is 1 every strobe is ignored, and the status word does not change until the operation-done pulse.
- R6: A status write with bit 1 set and mode (0,0) sets busy and clears bit 1. On the operation-done pulse it loads the block-protect bits 4:2, top/bottom bit 5, sector/block bit 6, protect-mode bits 8 (high) and 7 (low) and quad-enable bit 9. Data bits 1:0 and 15:10 are ignored, and bits 15:10 always read 0. A status write with bit 1 clear is refused.
- R7: In mode (0,1) a status write is refused while the write-protect pin is low: busy stays 0, bit 1 clears and the word is unchanged. With the pin high, the write is accepted.
- R8: In mode (1,0) every status write is refused. A power-up reset returns the mode to (0,0) and keeps the other non-volatile bits.
- R9: Once mode (1,1) has been written, every later status write is refused, also after any number of power-up resets. Program and erase stay governed by bit 1 alone.
- R10: While quad-enable is 1, the write-protect pin is treated as high, so mode (0,1) does not lock the status word.
- R11: `array_wr_ok_o` is 1 exactly when bit 1 is 1 and busy is 0. `sr_wr_ok_o` is 1 when, in addition, the current mode and pin allow a status write.
- R12: An operation-done pulse while busy is 0 has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| wren_i | input | 1 | Write-enable instruction strobe |
| wrdi_i | input | 1 | Write-disable instruction strobe |
| wrsr_i | input | 1 | Status-write instruction strobe |
| wr_data_i | input | 16 | New status value, sampled with `wrsr_i` |
| prog_i | input | 1 | Page-program instruction strobe |
| erase_i | input | 1 | Erase instruction strobe (any size) |
| wp_n_i | input | 1 | Active-low write-protect pin |
| op_done_i | input | 1 | Pulse that marks the end of the running operation |
| status_o | output | 16 | Status word |
| array_wr_ok_o | output | 1 | Program or erase would be accepted now |
| sr_wr_ok_o | output | 1 | Status write would be accepted now |

## Verification
The properties assume that the decoder raises at most one instruction strobe per cycle. Most of them also assume that an operation-done pulse comes only after the block has started an operation, which is needed for the check that the status word holds still while idle. The directed tasks pulse each strobe by itself for one cycle. They raise operation-done only after busy has risen, except in the single task that checks a stray done pulse, and that task drives no strobe alongside it.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

  typedef enum logic [1:0] {
    PM_SOFT    = 2'b00,
    PM_PIN     = 2'b01,
    PM_CYCLE   = 2'b10,
    PM_FOREVER = 2'b11
  } prot_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_WRSR  = 3'd1,
    CMD_PROG  = 3'd2,
    CMD_ERASE = 3'd3,
    CMD_WREN  = 3'd4,
    CMD_WRDI  = 3'd5
  } cmd_e;

  function automatic logic is_array_cmd(input cmd_e c);
    return (c == CMD_PROG) || (c == CMD_ERASE);
  endfunction

endpackage

// File: rtl/sreg_cmd_arb.sv
module sreg_cmd_arb
  import sreg_guard_pkg::*;
(
  input  logic busy,
  input  logic wren,
  input  logic wrdi,
  input  logic wrsr,
  input  logic prog,
  input  logic erase,
  output cmd_e cmd
);
  // Fixed priority; nothing passes while an operation runs.
  always_comb begin
    cmd = CMD_NONE;
    if (!busy) begin
      if (wrsr)       cmd = CMD_WRSR;
      else if (prog)  cmd = CMD_PROG;
      else if (erase) cmd = CMD_ERASE;
      else if (wren)  cmd = CMD_WREN;
      else if (wrdi)  cmd = CMD_WRDI;
    end
  end
endmodule

// File: rtl/sreg_lock_eval.sv
module sreg_lock_eval
  import sreg_guard_pkg::*;
(
  input  prot_mode_e mode,
  input  logic       perm,
  input  logic       qe,
  input  logic       wp_n,
  output logic       locked
);
  logic pin_high;

  // Quad mode takes the pin over as data, so it reads as high.
  assign pin_high = wp_n | qe;

  always_comb begin
    unique case (mode)
      PM_SOFT:    locked = 1'b0;
      PM_PIN:     locked = ~pin_high;
      PM_CYCLE:   locked = 1'b1;
      PM_FOREVER: locked = 1'b1;
      default:    locked = 1'b1;
    endcase
    if (perm) locked = 1'b1;
  end
endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
  import sreg_guard_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cmd_e          cmd,
  input  logic          locked,
  input  logic          op_done,
  input  logic [PW-1:0] new_fields,
  output logic          busy,
  output logic          wel,
  output logic          commit,
  output logic [PW-1:0] commit_fields
);
  logic          busy_q = 1'b0;
  logic          wel_q  = 1'b0;
  logic          pend_q = 1'b0;
  logic [PW-1:0] pdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (busy_q) begin
      if (op_done) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end
    end else begin
      unique case (cmd)
        CMD_WREN: wel_q <= 1'b1;
        CMD_WRDI: wel_q <= 1'b0;
        CMD_PROG, CMD_ERASE: begin
          wel_q <= 1'b0;
          if (wel_q) busy_q <= 1'b1;
        end
        CMD_WRSR: begin
          wel_q <= 1'b0;
          if (wel_q && !locked) begin
            busy_q <= 1'b1;
            pend_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Pending value register, no reset needed.
  always_ff @(posedge clk) begin
    if (!busy_q && cmd == CMD_WRSR) pdata_q <= new_fields;
  end

  assign busy          = busy_q;
  assign wel           = wel_q;
  assign commit        = busy_q & op_done & pend_q & ~rst;
  assign commit_fields = pdata_q;
endmodule

// File: rtl/sreg_nv.sv
module sreg_nv
  import sreg_guard_pkg::*;
#(
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            commit,
  input  logic [BP_W-1:0] new_bp,
  input  logic            new_tb,
  input  logic            new_sec,
  input  prot_mode_e      new_mode,
  input  logic            new_qe,
  output logic [BP_W-1:0] bp,
  output logic            tb,
  output logic            sec,
  output prot_mode_e      mode,
  output logic            qe,
  output logic            perm
);
  // Non-volatile fields: configuration-time defaults, kept over rst.
  logic [BP_W-1:0] bp_q   = '0;
  logic            tb_q   = 1'b0;
  logic            sec_q  = 1'b0;
  prot_mode_e      mode_q = PM_SOFT;
  logic            qe_q   = 1'b0;
  logic            perm_q = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      if (mode_q == PM_CYCLE) mode_q <= PM_SOFT;
    end else if (commit) begin
      bp_q   <= new_bp;
      tb_q   <= new_tb;
      sec_q  <= new_sec;
      mode_q <= new_mode;
      qe_q   <= new_qe;
    end
  end

  // Sticky permanent lock; power-up reset never clears it.
  always_ff @(posedge clk) begin
    if (!rst && commit && new_mode == PM_FOREVER) perm_q <= 1'b1;
  end

  assign bp   = bp_q;
  assign tb   = tb_q;
  assign sec  = sec_q;
  assign mode = mode_q;
  assign qe   = qe_q;
  assign perm = perm_q;
endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int SR_W = 16,
  parameter int BP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wren_i,
  input  logic            wrdi_i,
  input  logic            wrsr_i,
  input  logic [SR_W-1:0] wr_data_i,
  input  logic            prog_i,
  input  logic            erase_i,
  input  logic            wp_n_i,
  input  logic            op_done_i,
  output logic [SR_W-1:0] status_o,
  output logic            array_wr_ok_o,
  output logic            sr_wr_ok_o
);
  localparam int BUSY_BIT = 0;
  localparam int WEL_BIT  = 1;
  localparam int BP_LSB   = 2;
  localparam int TB_BIT   = BP_LSB + BP_W;
  localparam int SEC_BIT  = TB_BIT + 1;
  localparam int SRP0_BIT = SEC_BIT + 1;
  localparam int SRP1_BIT = SRP0_BIT + 1;
  localparam int QE_BIT   = SRP1_BIT + 1;
  localparam int FW       = QE_BIT - BP_LSB + 1;

  cmd_e            cmd;
  logic            busy, wel, locked, commit;
  logic [FW-1:0]   fields_in, fields_c;
  logic [BP_W-1:0] bp;
  logic            tb, sec, qe, perm;
  prot_mode_e      mode;
  logic            unused_data;

  assign fields_in   = wr_data_i[QE_BIT:BP_LSB];
  assign unused_data = ^{wr_data_i[WEL_BIT:BUSY_BIT], wr_data_i[SR_W-1:QE_BIT+1]};

  sreg_cmd_arb u_arb (
    .busy (busy),
    .wren (wren_i),
    .wrdi (wrdi_i),
    .wrsr (wrsr_i),
    .prog (prog_i),
    .erase(erase_i),
    .cmd  (cmd)
  );

  sreg_lock_eval u_lock (
    .mode  (mode),
    .perm  (perm),
    .qe    (qe),
    .wp_n  (wp_n_i),
    .locked(locked)
  );

  sreg_ctrl #(.PW(FW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .cmd          (cmd),
    .locked       (locked),
    .op_done      (op_done_i),
    .new_fields   (fields_in),
    .busy         (busy),
    .wel          (wel),
    .commit       (commit),
    .commit_fields(fields_c)
  );

  sreg_nv #(.BP_W(BP_W)) u_nv (
    .clk     (clk),
    .rst     (rst),
    .commit  (commit),
    .new_bp  (fields_c[BP_W-1:0]),
    .new_tb  (fields_c[TB_BIT-BP_LSB]),
    .new_sec (fields_c[SEC_BIT-BP_LSB]),
    .new_mode(prot_mode_e'({fields_c[SRP1_BIT-BP_LSB], fields_c[SRP0_BIT-BP_LSB]})),
    .new_qe  (fields_c[QE_BIT-BP_LSB]),
    .bp      (bp),
    .tb      (tb),
    .sec     (sec),
    .mode    (mode),
    .qe      (qe),
    .perm    (perm)
  );

  assign status_o[BUSY_BIT]          = busy;
  assign status_o[WEL_BIT]           = wel;
  assign status_o[TB_BIT-1:BP_LSB]   = bp;
  assign status_o[TB_BIT]            = tb;
  assign status_o[SEC_BIT]           = sec;
  assign status_o[SRP0_BIT]          = mode[0];
  assign status_o[SRP1_BIT]          = mode[1];
  assign status_o[QE_BIT]            = qe;

  generate
    if (SR_W > QE_BIT + 1) begin : g_pad
      assign status_o[SR_W-1:QE_BIT+1] = '0;
    end
  endgenerate

  assign array_wr_ok_o = wel & ~busy;
  assign sr_wr_ok_o    = wel & ~busy & ~locked;
endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
  parameter int SR_W = 16,
  parameter int BP_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wren_i,
  input logic            wrdi_i,
  input logic            wrsr_i,
  input logic            prog_i,
  input logic            erase_i,
  input logic            wp_n_i,
  input logic            op_done_i,
  input logic [SR_W-1:0] status_o,
  input logic            array_wr_ok_o,
  input logic            sr_wr_ok_o
);
  localparam int SRP0_BIT = 2 + BP_W + 2;
  localparam int SRP1_BIT = SRP0_BIT + 1;
  localparam int QE_BIT   = SRP1_BIT + 1;

  logic       busy, wel, qe, any_cmd;
  logic [1:0] mode;
  assign busy    = status_o[0];
  assign wel     = status_o[1];
  assign qe      = status_o[QE_BIT];
  assign mode    = {status_o[SRP1_BIT], status_o[SRP0_BIT]};
  assign any_cmd = wren_i | wrdi_i | wrsr_i | prog_i | erase_i;

  // Input assumption: one strobe per cycle (R5 bench discipline)
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wren_i, wrdi_i, wrsr_i, prog_i, erase_i}));

  a_r2_wren_sets: assert property (@(posedge clk) disable iff (rst)
    (!busy && wren_i) |=> wel);

  a_r2_wrdi_clears: assert property (@(posedge clk) disable iff (rst)
    (!busy && wrdi_i) |=> !wel);

  a_r3_no_start_without_wel: assert property (@(posedge clk) disable iff (rst)
    (!busy && !wel && (prog_i || erase_i)) |=> !busy);

  a_r4_start_clears_wel: assert property (@(posedge clk) disable iff (rst)
    (!busy && wel && (prog_i || erase_i)) |=> (busy && !wel));

  a_r5_busy_freezes: assert property (@(posedge clk) disable iff (rst)
    (busy && !op_done_i) |=> (busy && $stable(status_o)));

  a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
    (busy && op_done_i) |=> !busy);

  a_r7_pin_lock: assert property (@(posedge clk) disable iff (rst)
    (!busy && wrsr_i && mode == 2'b01 && !wp_n_i && !qe) |=> !busy);

  a_r8_cycle_lock: assert property (@(posedge clk) disable iff (rst)
    (!busy && wrsr_i && mode == 2'b10) |=> !busy);

  a_r9_forever_mode: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (mode == 2'b11));

  a_r11_sr_implies_array: assert property (@(posedge clk) disable iff (rst)
    sr_wr_ok_o |-> array_wr_ok_o);

  a_r12_stray_done: assert property (@(posedge clk) disable iff (rst)
    (!busy && op_done_i && !any_cmd) |=> $stable(status_o));
endmodule

bind sreg_guard sreg_guard_chk #(.SR_W(SR_W), .BP_W(BP_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wren_i       (wren_i),
  .wrdi_i       (wrdi_i),
  .wrsr_i       (wrsr_i),
  .prog_i       (prog_i),
  .erase_i      (erase_i),
  .wp_n_i       (wp_n_i),
  .op_done_i    (op_done_i),
  .status_o     (status_o),
  .array_wr_ok_o(array_wr_ok_o),
  .sr_wr_ok_o   (sr_wr_ok_o)
);

// File: tb/sreg_guard_test.sv
`timescale 1ns/1ps
module sreg_guard_test;
  localparam logic [4:0] S_WREN = 5'b10000;
  localparam logic [4:0] S_WRDI = 5'b01000;
  localparam logic [4:0] S_WRSR = 5'b00100;
  localparam logic [4:0] S_PROG = 5'b00010;
  localparam logic [4:0] S_ERAS = 5'b00001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wren_i = 0, wrdi_i = 0, wrsr_i = 0, prog_i = 0, erase_i = 0;
  logic [15:0] wr_data_i = '0;
  logic        wp_n_i = 1'b1;
  logic        op_done_i = 1'b0;
  logic [15:0] status_o;
  logic        array_wr_ok_o, sr_wr_ok_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sreg_guard uut (
    .clk(clk), .rst(rst), .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
    .wr_data_i(wr_data_i), .prog_i(prog_i), .erase_i(erase_i), .wp_n_i(wp_n_i),
    .op_done_i(op_done_i), .status_o(status_o), .array_wr_ok_o(array_wr_ok_o),
    .sr_wr_ok_o(sr_wr_ok_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] s, input logic [15:0] d);
    {wren_i, wrdi_i, wrsr_i, prog_i, erase_i} = s;
    wr_data_i = d;
    tick();
    {wren_i, wrdi_i, wrsr_i, prog_i, erase_i} = '0;
  endtask

  task automatic finish_op();
    op_done_i = 1'b1;
    tick();
    op_done_i = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    tick();
  endtask

  // Status write with write-enable first, then completion.
  task automatic sr_write(input logic [15:0] d);
    issue(S_WREN, '0);
    issue(S_WRSR, d);
    finish_op();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 status", status_o, 16'h0000);
    check("R1 array flag", array_wr_ok_o, 0);
    check("R1 sr flag", sr_wr_ok_o, 0);
  endtask

  task automatic t_latch();
    issue(S_WREN, '0);
    check("R2 wel set", status_o, 16'h0002);
    check("R11 array flag", array_wr_ok_o, 1);
    check("R11 sr flag", sr_wr_ok_o, 1);
    issue(S_WRDI, '0);
    check("R2 wel clear", status_o, 16'h0000);
    check("R11 flag after wrdi", array_wr_ok_o, 0);
  endtask

  task automatic t_refused_array();
    issue(S_PROG, '0);
    check("R3 prog refused", status_o, 16'h0000);
    issue(S_ERAS, '0);
    check("R3 erase refused", status_o, 16'h0000);
  endtask

  task automatic t_array_op();
    issue(S_WREN, '0);
    issue(S_ERAS, '0);
    check("R4 busy wel", status_o, 16'h0001);
    check("R11 array busy", array_wr_ok_o, 0);
    repeat (5) tick();
    check("R4 busy held", status_o, 16'h0001);
    issue(S_WREN, '0);
    check("R5 wren ignored", status_o, 16'h0001);
    issue(S_WRSR, 16'h03FC);
    check("R5 wrsr ignored", status_o, 16'h0001);
    finish_op();
    check("R4 done", status_o, 16'h0000);
    issue(S_WREN, '0);
    issue(S_PROG, '0);
    check("R4 prog busy", status_o, 16'h0001);
    finish_op();
    check("R4 prog done", status_o, 16'h0000);
  endtask

  task automatic t_stray_done();
    issue(S_WREN, '0);
    finish_op();
    check("R12 stray done", status_o, 16'h0002);
    issue(S_WRDI, '0);
  endtask

  task automatic t_soft_write();
    issue(S_WRSR, 16'h0034);
    check("R6 no wel refused", status_o, 16'h0000);
    issue(S_WREN, '0);
    issue(S_WRSR, 16'hFC37);
    check("R6 pending", status_o, 16'h0001);
    finish_op();
    check("R6 committed", status_o, 16'h0034);
  endtask

  task automatic t_pin_mode();
    sr_write(16'h00B4);
    check("R6 mode01", status_o, 16'h00B4);
    wp_n_i = 1'b0;
    issue(S_WREN, '0);
    check("R7 sr flag low pin", sr_wr_ok_o, 0);
    check("R11 array with pin", array_wr_ok_o, 1);
    issue(S_WRSR, 16'h0080);
    check("R7 refused", status_o, 16'h00B4);
    wp_n_i = 1'b1;
    sr_write(16'h0280);
    check("R7 pin high ok", status_o, 16'h0280);
    wp_n_i = 1'b0;
    issue(S_WREN, '0);
    check("R10 qe pin ignored flag", sr_wr_ok_o, 1);
    issue(S_WRSR, 16'h0290);
    finish_op();
    check("R10 qe write", status_o, 16'h0290);
    wp_n_i = 1'b1;
  endtask

  task automatic t_cycle_lock();
    sr_write(16'h0110);
    check("R8 mode10", status_o, 16'h0110);
    issue(S_WREN, '0);
    check("R8 sr flag", sr_wr_ok_o, 0);
    issue(S_WRSR, 16'h0000);
    check("R8 refused", status_o, 16'h0110);
    do_reset();
    check("R8 after reset", status_o, 16'h0010);
  endtask

  task automatic t_forever();
    sr_write(16'h0188);
    check("R9 mode11", status_o, 16'h0188);
    issue(S_WREN, '0);
    issue(S_WRSR, 16'h0000);
    check("R9 refused", status_o, 16'h0188);
    do_reset();
    check("R9 after reset", status_o, 16'h0188);
    issue(S_WREN, '0);
    check("R9 sr flag", sr_wr_ok_o, 0);
    issue(S_WRSR, 16'h0000);
    check("R9 refused again", status_o, 16'h0188);
    issue(S_WREN, '0);
    issue(S_PROG, '0);
    check("R9 prog allowed", status_o, 16'h0189);
    finish_op();
    check("R9 prog done", status_o, 16'h0188);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_latch();
    t_refused_array();
    t_array_op();
    t_stray_done();
    t_soft_write();
    t_pin_mode();
    t_cycle_lock();
    t_forever();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule